// File: doc/BRIEF.md
# Lookahead Folded Priority Encoder

This block takes an N-bit request vector and returns a one-hot grant that marks the lowest-numbered request that is set. Bit 0 has the highest priority. A valid flag reports whether any request is present. The encoder is meant for arbiters, routers and match-line resolution, where many requesters compete and the first one wins.

The grant comes from a layered lookahead network rather than a bit-by-bit ripple. The input is cut into 8-bit cells, and each cell holds two 4-bit halves. A half suppresses its outputs when any lower request exists. Four cells make a 32-bit slice. Inside a slice, the lookahead of cell 0 is routed straight to cells 1 and 3. Slices are paired, and each pair receives one lookahead that is the OR of the activity in all lower pairs. The lookahead therefore jumps over intermediate slices instead of passing through them.

The grant and the valid flag can be registered with a parameter, which adds one cycle of latency. The width N must be a positive multiple of 32, and elaboration stops with an error for any other value.

Top module: `pe_lookahead_enc`

## Requirements
- R1: Grant bit i is high only when request bit i is set and every request bit below i is clear, so the grant equals the lowest set request bit.
- R2: The grant never has more than one bit high.
- R3: Valid is high when any request bit is set. With an all-zero request, the grant is all zeros and valid is low.
- R4: Valid is high exactly when the grant is nonzero.
- R5: Request bits above the lowest set bit have no effect on the grant, whatever their values.
- R6: Requests on both sides of an 8-bit cell boundary or a 32-bit slice boundary resolve to the lower bit. A lone request just above such a boundary is granted.
- R7: When OUT_REG is 1, the grant and valid seen after a rising clock edge reflect the request present at that edge, and they do not change between edges. When OUT_REG is 0, the outputs follow the request without a clock.
- R8: With OUT_REG set to 1, driving rst_ni low clears the grant and valid at once, without waiting for a clock edge, and they stay clear while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| req_i | input | N | Request vector; bit 0 has the highest priority |
| gnt_o | output | N | One-hot grant of the lowest set request |
| valid_o | output | 1 | High when any request is set |

## Verification
The bench builds the encoder with N = 128 and OUT_REG = 1. This gives four slices in two pairs, so the slice-level and pair-level lookahead paths are both exercised, including a pair whose lookahead has to skip a whole lower pair. Three sweeps run over every bit position: single requests, requests with every higher bit also set, and pairs of requests straddling each 8-bit boundary. Dense, sparse and shifted random vectors then reach lowest-set positions in every cell. The registered output also makes it possible to check the one-cycle latency and the asynchronous clear.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int unsigned HALF_W     = 4;
  localparam int unsigned MACRO_W    = 2 * HALF_W;
  localparam int unsigned SLICE_W    = 32;
  localparam int unsigned MACROS_PER = SLICE_W / MACRO_W;
endpackage

// File: rtl/pe_half4.sv
module pe_half4
  import pe_pkg::*;
(
  input  logic [HALF_W-1:0] req_i,
  input  logic              la_i,
  output logic [HALF_W-1:0] gnt_o
);
  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    localparam logic [HALF_W-1:0] LOWER = HALF_W'((1 << b) - 1);
    assign gnt_o[b] = req_i[b] & ~la_i & ~(|(req_i & LOWER));
  end
endmodule

// File: rtl/pe_macro8.sv
module pe_macro8
  import pe_pkg::*;
(
  input  logic [MACRO_W-1:0] req_i,
  input  logic               la_i,
  output logic [MACRO_W-1:0] gnt_o,
  output logic               any_o
);
  logic la_hi; // second-level lookahead into upper half

  assign any_o = |req_i;
  assign la_hi = (|req_i[HALF_W-1:0]) | la_i;

  pe_half4 u_lo (
    .req_i(req_i[HALF_W-1:0]),
    .la_i (la_i),
    .gnt_o(gnt_o[HALF_W-1:0])
  );

  pe_half4 u_hi (
    .req_i(req_i[MACRO_W-1:HALF_W]),
    .la_i (la_hi),
    .gnt_o(gnt_o[MACRO_W-1:HALF_W])
  );
endmodule

// File: rtl/pe_slice32.sv
module pe_slice32
  import pe_pkg::*;
(
  input  logic [SLICE_W-1:0] req_i,
  input  logic               la_i,
  output logic [SLICE_W-1:0] gnt_o,
  output logic               any_o
);
  logic [MACROS_PER-1:0] any_m;
  logic [MACROS_PER-1:0] la_m;
  logic                  la0;

  // 2x2 fold: macro 0 lookahead drives macros 1 and 3 directly
  assign la0     = la_i | any_m[0];
  assign la_m[0] = la_i;
  assign la_m[1] = la0;
  assign la_m[2] = la0 | any_m[1];
  assign la_m[3] = la0 | any_m[1] | any_m[2];
  assign any_o   = |any_m;

  for (genvar m = 0; m < MACROS_PER; m++) begin : g_macro
    pe_macro8 u_macro (
      .req_i(req_i[m*MACRO_W +: MACRO_W]),
      .la_i (la_m[m]),
      .gnt_o(gnt_o[m*MACRO_W +: MACRO_W]),
      .any_o(any_m[m])
    );
  end
endmodule

// File: rtl/pe_lookahead_enc.sv
module pe_lookahead_enc
  import pe_pkg::*;
#(
  parameter int unsigned N       = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         valid_o
);
  localparam int unsigned G = N / SLICE_W;
  localparam int unsigned P = (G + 1) / 2;

  if ((N % SLICE_W) != 0 || N == 0) begin : g_bad_width
    $error("pe_lookahead_enc: N must be a positive multiple of 32");
  end

  logic [G-1:0] grp_any;
  logic [G-1:0] grp_la;
  logic [P-1:0] pair_any;
  logic [P-1:0] pair_la;
  logic [N-1:0] gnt_c;
  logic         valid_c;

  for (genvar p = 0; p < P; p++) begin : g_pair
    if (2*p + 1 < G) begin : g_full
      assign pair_any[p] = grp_any[2*p] | grp_any[2*p+1];
    end else begin : g_lone
      assign pair_any[p] = grp_any[2*p];
    end
    if (p == 0) begin : g_first
      assign pair_la[p] = 1'b0;
    end else begin : g_rest
      // second-level fold: OR of all lower pairs, no pair-to-pair ripple
      localparam logic [P-1:0] BELOW = {P{1'b1}} >> (P - p);
      assign pair_la[p] = |(pair_any & BELOW);
    end
  end

  for (genvar g = 0; g < G; g++) begin : g_slice
    if (g % 2 == 0) begin : g_even
      assign grp_la[g] = pair_la[g/2];
    end else begin : g_odd
      assign grp_la[g] = pair_la[g/2] | grp_any[g-1];
    end
    pe_slice32 u_slice (
      .req_i(req_i[g*SLICE_W +: SLICE_W]),
      .la_i (grp_la[g]),
      .gnt_o(gnt_c[g*SLICE_W +: SLICE_W]),
      .any_o(grp_any[g])
    );
  end

  assign valid_c = |pair_any;

  if (OUT_REG) begin : g_reg
    logic [N-1:0] gnt_q;
    logic         valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gnt_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        gnt_q   <= gnt_c;
        valid_q <= valid_c;
      end
    end
    assign gnt_o   = gnt_q;
    assign valid_o = valid_q;
  end else begin : g_comb
    assign gnt_o   = gnt_c;
    assign valid_o = valid_c;
  end
endmodule

// File: rtl/pe_lookahead_enc_chk.sv
module pe_lookahead_enc_chk #(
  parameter int unsigned N       = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic [N-1:0] gnt_o,
  input logic         valid_o
);
  logic         primed;
  logic         held_rst;
  logic [N-1:0] ref_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  always_ff @(posedge clk_i) held_rst <= !rst_ni;

  if (OUT_REG) begin : g_reg
    logic [N-1:0] req_q;
    always_ff @(posedge clk_i) req_q <= req_i;
    assign ref_req = req_q;
  end else begin : g_comb
    assign ref_req = req_i;
  end

  assert_gnt_lowest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> gnt_o == (ref_req & (~ref_req + 1'b1)));

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_valid_any_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> valid_o == (|ref_req));

  assert_valid_gnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (gnt_o != '0));

  always @(posedge clk_i) begin
    if (OUT_REG && !rst_ni && held_rst)
      assert_reset_clear_R8: assert (gnt_o == '0 && !valid_o);
  end
endmodule

bind pe_lookahead_enc pe_lookahead_enc_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_pe_lookahead_enc.sv
`timescale 1ns/1ps
module tb_pe_lookahead_enc;
  localparam int unsigned N = 128;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] gnt_o;
  logic         valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pe_lookahead_enc #(.N(N), .OUT_REG(1'b1)) dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .gnt_o  (gnt_o),
    .valid_o(valid_o)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [N-1:0] rnd_vec();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic cmp(input string tag, input logic [N-1:0] exp_g, input logic exp_v);
    total++;
    if (gnt_o !== exp_g) begin
      bad++;
      $display("FAIL %s grant act=%h exp=%h", tag, gnt_o, exp_g);
    end
    total++;
    if (valid_o !== exp_v) begin
      bad++;
      $display("FAIL %s valid act=%b exp=%b", tag, valid_o, exp_v);
    end
    total++;
    if ($countones(gnt_o) > 1) begin
      bad++;
      $display("FAIL R2 onehot act=%0d exp<=1", $countones(gnt_o));
    end
    total++;
    if (valid_o !== (gnt_o != '0)) begin
      bad++;
      $display("FAIL R4 valid/grant act=%b exp=%b", valid_o, (gnt_o != '0));
    end
  endtask

  // drive on a falling edge, sample at the next falling edge (one register)
  task automatic apply(input string tag, input logic [N-1:0] v);
    @(negedge clk_i);
    req_i = v;
    @(negedge clk_i);
    cmp(tag, lowest(v), |v);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b;
    // R8: reset state with a live request
    req_i = rnd_vec() | 1'b1;
    repeat (3) @(negedge clk_i);
    cmp("R8 reset", '0, 1'b0);
    rst_ni = 1'b1;

    // R3: all-zero request
    apply("R3 zero", '0);

    // R1: every single-bit request
    for (int i = 0; i < N; i++) apply("R1 single", {{(N-1){1'b0}}, 1'b1} << i);

    // R5: all bits at and above i set
    for (int i = 0; i < N; i++) apply("R5 upper", {N{1'b1}} << i);

    // R6: straddle and just-above each cell boundary
    for (int k = 8; k < N; k += 8) begin
      a = ({{(N-1){1'b0}}, 1'b1} << k) | ({{(N-1){1'b0}}, 1'b1} << (k-1));
      apply("R6 straddle", a);
      apply("R6 above", ({N{1'b1}} << k) & rnd_vec() | ({{(N-1){1'b0}}, 1'b1} << k));
    end

    // R1/R5: random dense, sparse and shifted vectors
    for (int i = 0; i < 300; i++) apply("R1 dense", rnd_vec());
    for (int i = 0; i < 300; i++) apply("R5 sparse", rnd_vec() & rnd_vec() & rnd_vec());
    for (int i = 0; i < 300; i++) apply("R5 shifted", rnd_vec() << ($urandom() % N));

    // R7: output holds the old result until the next rising edge
    a = rnd_vec() | (1 << 20);
    b = {N{1'b1}} << 100;
    apply("R7 first", a);
    @(negedge clk_i);
    req_i = b;
    #1;
    cmp("R7 hold", lowest(a), 1'b1);
    @(negedge clk_i);
    cmp("R7 update", lowest(b), 1'b1);

    // R8: asynchronous clear mid-run, then recovery
    apply("R8 pre", ({{(N-1){1'b0}}, 1'b1} << 77));
    #1;
    rst_ni = 1'b0;
    #0.5;
    cmp("R8 async", '0, 1'b0);
    repeat (2) @(negedge clk_i);
    cmp("R8 held", '0, 1'b0);
    rst_ni = 1'b1;
    apply("R8 after", ({{(N-1){1'b0}}, 1'b1} << 77));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule